// File: doc/BRIEF.md
# Lockstep Six-Read Two-Write State Memory

This block stores the circular state of a long-period linear recurrence: 624 words of 32 bits, seen as a logical window indexed 0 to 623. Each accepted step returns six words of the current window and writes two new words. The window then shifts by one position. The new hot word enters at position 0, the tail write enters at position 1, every other word moves up by one, and the word at position 623 drops out. The recurrence arithmetic lives outside the block and feeds its results back as the two write words.

Position 0 is kept in a dedicated register, which gives one read and one write. The other positions sit in three dual-port RAM banks, selected by physical address modulo 3, each bank 208 words deep. A single base pointer moves every port address together. The five read offsets (70, 179, 450, 622, 623) and the write offset (0) are chosen so that their residues modulo 3 cover each bank exactly twice. Because the pointer moves all addresses by the same amount, that balance holds at every base value.

A seeding path loads the state. Each word accepted in seed mode lands at the next logical position, starting from 0. Seeding also returns the base pointer to zero. Steps use valid/ready. `step_ready` is low for the whole of seed mode, so steps are held off while seeding. `seed_ready` is high only in seed mode. The read results carry a valid flag and no ready. A consumer takes them in the cycle that `rd_valid` is high, and they then stay stable until the next result.

Top module: `lockstep_state_mem`

## Requirements
- R1: During and right after reset, `rd_valid` is low, `step_ready` is high and `seed_ready` is low.
- R2: While `seed_mode` is high, `seed_ready` is high and `step_ready` is low. Counting from 0 after `seed_mode` rises, the j-th word taken with `seed_valid` high becomes logical word j.
- R3: An accepted step (`step_valid` and `step_ready` both high at a rising edge) raises `rd_valid` for exactly the next cycle. Lane k, in `rd_data[32k+31:32k]`, then holds the logical words 0, 70, 179, 450, 622 and 623 (k = 0 to 5) as they stood before that step.
- R4: After an accepted step, logical word 0 equals that step's `hot_wdata` and word 1 equals its `tail_wdata`. Word j takes the old word j-1 for j from 2 to 623, and the old word 623 is discarded.
- R5: While `rd_valid` is low, `rd_data` keeps its previous value.
- R6: A cycle with no accepted step leaves the stored state unchanged.
- R7: No RAM bank is ever offered more than two accesses in one cycle. Back-to-back steps on every cycle return correct data.
- R8: The base pointer wraps modulo 624, and results stay correct after more than 624 steps.
- R9: Entering seed mode after any number of steps restarts the pointer at zero, so a fresh seed gives the same layout as the first one.
- R10: `step_valid` raised during seed mode has no effect on the state or on `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| seed_mode | input | 1 | Selects seeding; holds the pointer at zero |
| seed_valid | input | 1 | Seed word present |
| seed_ready | output | 1 | Seed word accepted (high in seed mode) |
| seed_data | input | 32 | Seed word |
| step_valid | input | 1 | Step request with its two write words |
| step_ready | output | 1 | Step can be taken (low in seed mode) |
| hot_wdata | input | 32 | New logical word 0 |
| tail_wdata | input | 32 | New logical word 1 |
| rd_valid | output | 1 | Read lanes valid for this cycle |
| rd_data | output | 192 | Six 32-bit read lanes, lane 0 in the low bits |

## Verification
A wrong bank or port choice in the crossbar, or a pointer that is off by one, shows up as a wrong word on one of the five RAM lanes one cycle after the step that uses it. A broken shift shows up as a wrong lane 622 or 623 result after one step, or as a wrong lane 70 result within 70 steps. Seeding errors appear on the first step after seed mode, because that step reads seeded positions directly. Wrap faults surface on the first step past 624. Back-to-back runs drive every bank rotation, so a routing collision corrupts a lane within three steps.

// File: rtl/smem_pkg.sv
package smem_pkg;
  // Request slots presented to the crossbar: five RAM reads then one RAM write.
  localparam int unsigned RAM_READS = 5;
  localparam int unsigned XBAR_REQS = RAM_READS + 1;
  // Output lanes: the hot register plus the RAM reads.
  localparam int unsigned OUT_LANES = RAM_READS + 1;
  // Ports on every bank.
  localparam int unsigned BANK_PORTS = 2;
endpackage

// File: rtl/smem_addr_gen.sv
module smem_addr_gen #(
  parameter int unsigned N    = 624,
  parameter int unsigned NRD  = 5,
  parameter int unsigned AW   = 10,
  parameter logic [NRD*AW-1:0] OFFS = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          seed_mode,
  input  logic          advance,
  input  logic          seed_take,
  output logic [AW-1:0] base,
  output logic [AW-1:0] seed_idx,
  output logic [AW-1:0] rd_addr [NRD],
  output logic [AW-1:0] wr_addr
);
  localparam logic [AW:0]   N_EXT = (AW+1)'(N);
  localparam logic [AW-1:0] LAST  = AW'(N - 1);

  function automatic logic [AW-1:0] circ_add(input logic [AW-1:0] a, input logic [AW-1:0] b);
    logic [AW:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= N_EXT) s = s - N_EXT;
    return s[AW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base     <= '0;
      seed_idx <= '0;
    end else begin
      if (seed_mode)    base <= '0;
      else if (advance) base <= (base == '0) ? LAST : base - AW'(1);

      if (!seed_mode)     seed_idx <= '0;
      else if (seed_take) seed_idx <= (seed_idx == LAST) ? '0 : seed_idx + AW'(1);
    end
  end

  for (genvar k = 0; k < NRD; k++) begin : g_rd
    assign rd_addr[k] = circ_add(base, OFFS[k*AW +: AW]);
  end

  assign wr_addr = seed_mode ? seed_idx : base;
endmodule

// File: rtl/smem_xbar.sv
module smem_xbar #(
  parameter int unsigned W     = 32,
  parameter int unsigned AW    = 10,
  parameter int unsigned IW    = 8,
  parameter int unsigned BW    = 2,
  parameter int unsigned NBANK = 3,
  parameter int unsigned NREQ  = 6
) (
  input  logic                req_en   [NREQ],
  input  logic                req_we   [NREQ],
  input  logic [AW-1:0]       req_addr [NREQ],
  input  logic [W-1:0]        wdata,
  output logic [1:0]          port_en  [NBANK],
  output logic [1:0]          port_we  [NBANK],
  output logic [1:0][IW-1:0]  port_idx [NBANK],
  output logic [1:0][W-1:0]   port_wd  [NBANK],
  output logic [BW-1:0]       req_bank [NREQ],
  output logic                req_port [NREQ],
  output logic                overload
);
  function automatic logic [BW-1:0] bank_of(input logic [AW-1:0] a);
    return BW'(a % AW'(NBANK));
  endfunction

  function automatic logic [IW-1:0] row_of(input logic [AW-1:0] a);
    return IW'(a / AW'(NBANK));
  endfunction

  always_comb begin
    overload = 1'b0;
    for (int r = 0; r < NREQ; r++) begin
      req_bank[r] = bank_of(req_addr[r]);
      req_port[r] = 1'b0;
    end
    for (int b = 0; b < NBANK; b++) begin
      port_en[b]  = '0;
      port_we[b]  = '0;
      port_idx[b] = '0;
      port_wd[b]  = '0;
    end
    for (int b = 0; b < NBANK; b++) begin
      int unsigned used;
      used = 0;
      for (int r = 0; r < NREQ; r++) begin
        if (req_en[r] && bank_of(req_addr[r]) == BW'(b)) begin
          if (used < 2) begin
            port_en[b][used]  = 1'b1;
            port_we[b][used]  = req_we[r];
            port_idx[b][used] = row_of(req_addr[r]);
            port_wd[b][used]  = req_we[r] ? wdata : '0;
            req_port[r]       = (used == 1);
          end
          used = used + 1;
        end
      end
      if (used > 2) overload = 1'b1;
    end
  end
endmodule

// File: rtl/smem_bank.sv
module smem_bank #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 208,
  parameter int unsigned IW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          en,
  input  logic [1:0]          we,
  input  logic [1:0][IW-1:0]  idx,
  input  logic [1:0][W-1:0]   wd,
  output logic [1:0][W-1:0]   rd
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int p = 0; p < 2; p++) begin
      if (en[p] && we[p]) mem[idx[p]] <= wd[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd <= '0;
    end else begin
      for (int p = 0; p < 2; p++) begin
        if (en[p] && !we[p]) rd[p] <= mem[idx[p]];
      end
    end
  end
endmodule

// File: rtl/lockstep_state_mem.sv
module lockstep_state_mem
  import smem_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned N     = 624,
  parameter int unsigned NBANK = 3,
  parameter int unsigned OFF1  = 70,
  parameter int unsigned OFF2  = 179,
  parameter int unsigned OFF3  = 450,
  parameter int unsigned OFF4  = 622,
  parameter int unsigned OFF5  = 623
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   seed_mode,
  input  logic                   seed_valid,
  output logic                   seed_ready,
  input  logic [W-1:0]           seed_data,
  input  logic                   step_valid,
  output logic                   step_ready,
  input  logic [W-1:0]           hot_wdata,
  input  logic [W-1:0]           tail_wdata,
  output logic                   rd_valid,
  output logic [OUT_LANES*W-1:0] rd_data
);
  localparam int unsigned AW    = $clog2(N);
  localparam int unsigned DEPTH = N / NBANK;
  localparam int unsigned IW    = $clog2(DEPTH);
  localparam int unsigned BW    = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam logic [RAM_READS*AW-1:0] OFFS =
    {AW'(OFF5), AW'(OFF4), AW'(OFF3), AW'(OFF2), AW'(OFF1)};

  logic          fire, seed_take;
  logic [AW-1:0] ag_base, seed_idx, wr_addr;
  logic [AW-1:0] rd_addr [RAM_READS];

  assign step_ready = !seed_mode;
  assign seed_ready = seed_mode;
  assign fire       = step_valid && step_ready;
  assign seed_take  = seed_valid && seed_mode;

  smem_addr_gen #(.N(N), .NRD(RAM_READS), .AW(AW), .OFFS(OFFS)) u_addr (
    .clk(clk), .rst_n(rst_n), .seed_mode(seed_mode), .advance(fire),
    .seed_take(seed_take), .base(ag_base), .seed_idx(seed_idx),
    .rd_addr(rd_addr), .wr_addr(wr_addr)
  );

  // Crossbar requests: slots 0..4 read, slot 5 writes tail data or seed data.
  logic                req_en   [XBAR_REQS];
  logic                req_we   [XBAR_REQS];
  logic [AW-1:0]       req_addr [XBAR_REQS];
  logic [BW-1:0]       req_bank [XBAR_REQS];
  logic                req_port [XBAR_REQS];
  logic [W-1:0]        xbar_wdata;
  logic                xbar_overload;
  logic [1:0]          port_en  [NBANK];
  logic [1:0]          port_we  [NBANK];
  logic [1:0][IW-1:0]  port_idx [NBANK];
  logic [1:0][W-1:0]   port_wd  [NBANK];
  logic [1:0][W-1:0]   bank_rd  [NBANK];

  for (genvar r = 0; r < RAM_READS; r++) begin : g_req
    assign req_en[r]   = fire;
    assign req_we[r]   = 1'b0;
    assign req_addr[r] = rd_addr[r];
  end
  assign req_en[RAM_READS]   = fire || (seed_take && seed_idx != '0);
  assign req_we[RAM_READS]   = 1'b1;
  assign req_addr[RAM_READS] = wr_addr;
  assign xbar_wdata          = seed_mode ? seed_data : tail_wdata;

  smem_xbar #(.W(W), .AW(AW), .IW(IW), .BW(BW), .NBANK(NBANK), .NREQ(XBAR_REQS)) u_xbar (
    .req_en(req_en), .req_we(req_we), .req_addr(req_addr), .wdata(xbar_wdata),
    .port_en(port_en), .port_we(port_we), .port_idx(port_idx), .port_wd(port_wd),
    .req_bank(req_bank), .req_port(req_port), .overload(xbar_overload)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    smem_bank #(.W(W), .DEPTH(DEPTH), .IW(IW)) u_bank (
      .clk(clk), .rst_n(rst_n), .en(port_en[g]), .we(port_we[g]),
      .idx(port_idx[g]), .wd(port_wd[g]), .rd(bank_rd[g])
    );
  end

  // Hot word register and the read-return pipeline stage.
  logic [W-1:0]  hot_q, hot_rd_q;
  logic          rd_valid_q;
  logic [BW-1:0] lane_bank_q [RAM_READS];
  logic          lane_port_q [RAM_READS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hot_q      <= '0;
      hot_rd_q   <= '0;
      rd_valid_q <= 1'b0;
      for (int r = 0; r < RAM_READS; r++) begin
        lane_bank_q[r] <= '0;
        lane_port_q[r] <= 1'b0;
      end
    end else begin
      rd_valid_q <= fire;
      if (seed_take && seed_idx == '0) hot_q <= seed_data;
      else if (fire)                   hot_q <= hot_wdata;
      if (fire) begin
        hot_rd_q <= hot_q;
        for (int r = 0; r < RAM_READS; r++) begin
          lane_bank_q[r] <= req_bank[r];
          lane_port_q[r] <= req_port[r];
        end
      end
    end
  end

  assign rd_valid       = rd_valid_q;
  assign rd_data[0 +: W] = hot_rd_q;
  for (genvar r = 0; r < RAM_READS; r++) begin : g_lane
    assign rd_data[(r+1)*W +: W] = bank_rd[lane_bank_q[r]][lane_port_q[r]];
  end
endmodule

// File: rtl/lockstep_state_mem_chk.sv
module lockstep_state_mem_chk #(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = 10,
  parameter int unsigned N  = 624
) (
  input logic          clk,
  input logic          rst_n,
  input logic          seed_mode,
  input logic          seed_ready,
  input logic          step_valid,
  input logic          step_ready,
  input logic          rd_valid,
  input logic [6*W-1:0] rd_data,
  input logic          overload,
  input logic [AW-1:0] base
);
  // R7
  bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n) !overload);

  // R2
  seed_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seed_mode |-> (seed_ready && !step_ready));

  // R3
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && step_ready) |=> rd_valid);

  // R3
  rd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(step_valid && step_ready));

  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_data));

  // R9
  seed_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seed_mode |=> (base == '0));

  // R8
  base_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base < AW'(N));
endmodule

bind lockstep_state_mem lockstep_state_mem_chk #(.W(W), .AW(AW), .N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .seed_mode(seed_mode), .seed_ready(seed_ready),
  .step_valid(step_valid), .step_ready(step_ready), .rd_valid(rd_valid),
  .rd_data(rd_data), .overload(xbar_overload), .base(ag_base)
);

// File: tb/lockstep_state_mem_tb.sv
module lockstep_state_mem_tb;
  localparam int N = 624;
  localparam int OFFS [6] = '{0, 70, 179, 450, 622, 623};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seed_mode = 1'b0, seed_valid = 1'b0, step_valid = 1'b0;
  logic [31:0] seed_data = '0, hot_wdata = '0, tail_wdata = '0;
  logic seed_ready, step_ready, rd_valid;
  logic [191:0] rd_data;

  always #4 clk = ~clk;

  lockstep_state_mem u_dut (
    .clk(clk), .rst_n(rst_n), .seed_mode(seed_mode), .seed_valid(seed_valid),
    .seed_ready(seed_ready), .seed_data(seed_data), .step_valid(step_valid),
    .step_ready(step_ready), .hot_wdata(hot_wdata), .tail_wdata(tail_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int checks = 0, fails = 0, fired = 0, seed_cnt = 0;
  bit done = 1'b0, exp_valid = 1'b0, have_last = 1'b0;
  logic [31:0] model [N];
  logic [31:0] exp_lanes [6];
  logic [31:0] last_lanes [6];
  string phase = "R2";

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One cycle: verify what the last edge produced, then drive and update the model.
  task automatic tick(input bit sm, input bit sv, input bit stv);
    logic [31:0] sd, hw, tw;
    sd = $urandom; hw = $urandom; tw = $urandom;
    @(negedge clk);
    chk({phase, " R3 rd_valid"}, {31'd0, rd_valid}, {31'd0, exp_valid});
    for (int k = 0; k < 6; k++) begin
      if (exp_valid) begin
        chk($sformatf("%s lane %0d", phase, k), rd_data[32*k +: 32], exp_lanes[k]);
        last_lanes[k] = exp_lanes[k];
      end else if (have_last) begin
        chk($sformatf("R5 hold lane %0d", k), rd_data[32*k +: 32], last_lanes[k]);
      end
    end
    if (exp_valid) have_last = 1'b1;
    seed_mode = sm; seed_valid = sv; seed_data = sd;
    step_valid = stv; hot_wdata = hw; tail_wdata = tw;
    #1;
    chk(sm ? "R2 step_ready" : "R10 step_ready", {31'd0, step_ready}, {31'd0, !sm});
    chk("R2 seed_ready", {31'd0, seed_ready}, {31'd0, sm});
    exp_valid = stv && !sm;
    if (exp_valid) begin
      for (int k = 0; k < 6; k++) exp_lanes[k] = model[OFFS[k]];
      for (int j = N - 1; j >= 2; j--) model[j] = model[j-1];
      model[1] = tw;
      model[0] = hw;
      fired++;
    end
    if (sm && sv) begin
      model[seed_cnt] = sd;
      seed_cnt = (seed_cnt == N - 1) ? 0 : seed_cnt + 1;
    end
    if (!sm) seed_cnt = 0;
  endtask

  task automatic seed_all();
    int taken;
    taken = 0;
    tick(1'b0, 1'b0, 1'b0);
    while (taken < N) begin
      bit v;
      v = ($urandom % 4) != 0;
      tick(1'b1, v, $urandom % 2 == 0);  // R10: steps offered while seeding
      if (v) taken++;
    end
    tick(1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd7341));
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    chk("R1 step_ready", {31'd0, step_ready}, 32'd1);
    chk("R1 seed_ready", {31'd0, seed_ready}, 32'd0);
    rst_n = 1'b1;
    chk("R1 rd_valid after release", {31'd0, rd_valid}, 32'd0);

    phase = "R2";
    seed_all();
    tick(1'b0, 1'b0, 1'b1);           // first step reads seeded positions
    phase = "R10";
    tick(1'b0, 1'b0, 1'b1);
    phase = "R7";                      // back-to-back steps through all rotations
    for (int i = 0; i < 700; i++) begin
      if (fired > N) phase = "R8";
      tick(1'b0, 1'b0, 1'b1);
    end
    phase = "R4";
    for (int i = 0; i < 400; i++) tick(1'b0, 1'b0, ($urandom % 4) != 0);
    phase = "R6";
    for (int i = 0; i < 20; i++) tick(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 80; i++) tick(1'b0, 1'b0, 1'b1);
    phase = "R9";
    seed_all();
    for (int i = 0; i < 300; i++) tick(1'b0, 1'b0, ($urandom % 3) != 0);
    tick(1'b0, 1'b0, 1'b0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule